// File: doc/BRIEF.md
# Multiplexed NAND Device Port Front End

This block is the device-side logic behind an 8-bit shared bus of the NAND type. One bus carries commands, address bytes and data. On each rising edge of the active-low write strobe, the levels of two select inputs decide which of these the byte is. The block keeps a command register, a five-byte address register and a column counter. It reacts to a small set of command sequences: read, program, erase and reset.

Program and erase are held back while write protect is active. An active-low ready/busy indication is driven while an operation runs. A deselected chip drops into standby, except while it is busy. A 16-byte staging buffer and a one-page array buffer stand in for the storage, and a fixed-length timer stands in for the operation time.

All pins are first passed through a synchronizer into the `clk` domain. A strobe takes effect about three clocks after its edge at the pin.

The controller is a single state machine with these states:
- `S_IDLE`
- `S_RD_ADDR`: read setup, collecting the address.
- `S_PG_LOAD`: program setup, collecting the address and then the data bytes.
- `S_ER_ADDR`: erase setup.
- `S_BUSY`: an operation is running on the timer.
- `S_RD_DATA`: the read-data phase.

Its transitions are:
- A setup command moves `S_IDLE` or `S_RD_DATA` to the matching setup state. A setup command seen in any other ready state does the same.
- Any other unexpected command returns to `S_IDLE`.
- In a setup state, the matching confirm command enters `S_BUSY`. Program and erase only do so when write protect is off; otherwise they go back to `S_IDLE`.
- When the busy timer expires, `S_BUSY` moves to `S_RD_DATA` after a read, and to `S_IDLE` after a program or erase.

Top module: `nand_port_frontend`

## Requirements
- R1: A write strobe rising edge with `cmd_sel_i`=1 and `addr_sel_i`=0 loads `dq_i` into the command register, which is visible on `cmd_o`. Only a ready, selected device does this.
- R2: A write strobe rising edge with `addr_sel_i`=1 and `cmd_sel_i`=0 loads the byte into `addr_o`. Byte k of a sequence goes to bits [8k+7:8k], low byte first. The byte counter returns to byte 0 after five bytes. Any setup command also resets it to byte 0.
- R3: A write strobe edge with both `cmd_sel_i` and `addr_sel_i` high changes none of `cmd_o`, `addr_o` and `col_o`.
- R4: In the program-load phase, a write strobe edge with both selects low stores the byte in the staging buffer at column bits [3:0]. It also increments `col_o` by one.
- R5: The command codes are:
  - read: 0x00 then 0x30
  - program: 0x80 then 0x10
  - erase: 0x60 then 0xD0
  - reset: 0xFF, which returns to idle
- R6: `rb_pull_o` is 1 (pulling the line low) for the whole of an operation and returns to 0 when it ends. The lengths are 8 clocks for a read, 20 for a program and 24 for an erase.
- R7: Each read strobe falling edge in the read-data phase has two effects. It places array byte `col_o`[3:0] on `dq_o` one clock after the edge is detected, and it increments `col_o`. The column is loaded from address byte 0 (upper bits cleared) and then from byte 1 as its upper byte.
- R8: `dq_oe_o` is 1 only while the chip is selected, the read strobe is low and the block is in the read-data phase.
- R9: With `csel_n_i` high and no operation running, `standby_o` is 1 and all strobes are ignored.
- R10: While busy, a high `csel_n_i` has no effect. The operation completes, `standby_o` stays 0, and standby begins only once the block is ready.
- R11: While `wprot_n_i` is 0, `supply_en_o` is 0. A program or erase confirm then leaves the block ready and the array unchanged.
- R12: When a program completes, the staging buffer is copied into the array. When an erase completes, every array byte becomes 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csel_n_i | input | 1 | Active-low chip select |
| cmd_sel_i | input | 1 | Marks the byte on the bus as a command |
| addr_sel_i | input | 1 | Marks the byte on the bus as an address |
| wstb_n_i | input | 1 | Active-low write strobe, acts on its rising edge |
| rstb_n_i | input | 1 | Active-low read strobe, acts on its falling edge |
| wprot_n_i | input | 1 | Active-low write protect |
| dq_i | input | 8 | Bus byte in |
| dq_o | output | 8 | Bus byte out |
| dq_oe_o | output | 1 | Bus output enable |
| rb_pull_o | output | 1 | 1 pulls the open-drain ready/busy line low |
| standby_o | output | 1 | Standby state |
| supply_en_o | output | 1 | Programming supply enable |
| cmd_o | output | 8 | Command register |
| addr_o | output | 40 | Address register |
| col_o | output | 16 | Column counter |

## Verification
Several rules are checked by assertions on every cycle:
- The command and address stay frozen while the block is in standby or busy.
- The bus is enabled only in the read-data phase and never while busy.
- The column steps by exactly one per read step.
- Any program or erase that enters busy does so with write protect off.

The returned data can only be shown by the bench's scenarios. The bench programs a page and then reads it back starting from every column, including wrap-around. The same holds for the cycle lengths of busy, the effect of erase, the blocked program and erase under write protect, and the address byte order with its wrap.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ADDR,
        S_PG_LOAD,
        S_ER_ADDR,
        S_BUSY,
        S_RD_DATA
    } fe_state_t;

    typedef enum logic [1:0] {
        K_READ,
        K_PROG,
        K_ERASE
    } op_kind_t;

    localparam logic [7:0] OP_RD_SETUP = 8'h00;
    localparam logic [7:0] OP_RD_GO    = 8'h30;
    localparam logic [7:0] OP_PG_SETUP = 8'h80;
    localparam logic [7:0] OP_PG_GO    = 8'h10;
    localparam logic [7:0] OP_ER_SETUP = 8'h60;
    localparam logic [7:0] OP_ER_GO    = 8'hD0;
    localparam logic [7:0] OP_RESET    = 8'hFF;

    function automatic fe_state_t setup_target(input logic [7:0] code);
        fe_state_t t;
        case (code)
            OP_RD_SETUP: t = S_RD_ADDR;
            OP_PG_SETUP: t = S_PG_LOAD;
            OP_ER_SETUP: t = S_ER_ADDR;
            default:     t = S_IDLE;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/nand_fe_sync.sv
module nand_fe_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/nand_fe_addr.sv
module nand_fe_addr #(
    parameter int ADDR_BYTES = 5,
    parameter int COL_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    addr_wr,
    input  logic [7:0]              byte_in,
    input  logic                    col_inc,
    output logic [8*ADDR_BYTES-1:0] addr_q,
    output logic [COL_W-1:0]        col_q
);
    localparam int CNT_W = $clog2(ADDR_BYTES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
            col_q  <= '0;
        end else begin
            if (clr) begin
                cnt_q <= '0;
            end else if (addr_wr) begin
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                for (int k = 0; k < ADDR_BYTES; k++) begin
                    if (cnt_q == CNT_W'(k)) addr_q[8*k +: 8] <= byte_in;
                end
                if (cnt_q == CNT_W'(0)) col_q <= COL_W'(byte_in);
                else if (cnt_q == CNT_W'(1)) col_q <= COL_W'({byte_in, col_q[7:0]});
            end
            if (col_inc && !addr_wr) col_q <= col_q + 1'b1;
        end
    end
endmodule

// File: rtl/nand_fe_buf.sv
module nand_fe_buf #(
    parameter int         DEPTH    = 16,
    parameter logic [7:0] ERASED   = 8'hFF,
    parameter int         IDX_W    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [7:0]           wr_data,
    input  logic                 fill_en,
    input  logic                 copy_en,
    input  logic [DEPTH*8-1:0]   copy_src,
    output logic [DEPTH*8-1:0]   mem_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_o <= {DEPTH{ERASED}};
        end else if (fill_en) begin
            mem_o <= {DEPTH{ERASED}};
        end else if (copy_en) begin
            mem_o <= copy_src;
        end else if (wr_en) begin
            mem_o[{wr_idx, 3'b000} +: 8] <= wr_data;
        end
    end
endmodule

// File: rtl/nand_port_frontend.sv
module nand_port_frontend
    import nand_fe_pkg::*;
#(
    parameter int BUF_DEPTH   = 16,
    parameter int ADDR_BYTES  = 5,
    parameter int COL_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_RD     = 8,
    parameter int BUSY_PG     = 20,
    parameter int BUSY_ER     = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    csel_n_i,
    input  logic                    cmd_sel_i,
    input  logic                    addr_sel_i,
    input  logic                    wstb_n_i,
    input  logic                    rstb_n_i,
    input  logic                    wprot_n_i,
    input  logic [7:0]              dq_i,
    output logic [7:0]              dq_o,
    output logic                    dq_oe_o,
    output logic                    rb_pull_o,
    output logic                    standby_o,
    output logic                    supply_en_o,
    output logic [7:0]              cmd_o,
    output logic [8*ADDR_BYTES-1:0] addr_o,
    output logic [COL_W-1:0]        col_o
);
    localparam int IDX_W    = $clog2(BUF_DEPTH);
    localparam int MAX_BUSY = (BUSY_PG > BUSY_ER) ? ((BUSY_PG > BUSY_RD) ? BUSY_PG : BUSY_RD)
                                                  : ((BUSY_ER > BUSY_RD) ? BUSY_ER : BUSY_RD);
    localparam int TMR_W    = $clog2(MAX_BUSY + 1);
    localparam int SYN_W    = 14;

    // synchronized pins
    logic [SYN_W-1:0] syn_q;
    logic [7:0]       s_dq;
    logic             s_csel_n, s_cmd, s_adr, s_wstb_n, s_rstb_n, s_wp_n;

    nand_fe_sync #(
        .W       (SYN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({8'h00, 6'b100110})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dq_i, csel_n_i, cmd_sel_i, addr_sel_i, wstb_n_i, rstb_n_i, wprot_n_i}),
        .q     (syn_q)
    );

    assign s_dq     = syn_q[13:6];
    assign s_csel_n = syn_q[5];
    assign s_cmd    = syn_q[4];
    assign s_adr    = syn_q[3];
    assign s_wstb_n = syn_q[2];
    assign s_rstb_n = syn_q[1];
    assign s_wp_n   = syn_q[0];

    // strobe edge detection
    logic wstb_last, rstb_last;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wstb_last <= 1'b1;
            rstb_last <= 1'b1;
        end else begin
            wstb_last <= s_wstb_n;
            rstb_last <= s_rstb_n;
        end
    end

    logic we_rise, re_fall;
    assign we_rise = s_wstb_n & ~wstb_last;
    assign re_fall = ~s_rstb_n & rstb_last;

    // controller state
    fe_state_t        state_q, state_d;
    op_kind_t         kind_q, kind_d;
    logic [TMR_W-1:0] tmr_q, tmr_d;

    logic busy, active;
    logic is_cmd, is_adr, is_dat, rd_step, addr_clr;
    logic arr_prog, arr_erase;

    assign busy    = (state_q == S_BUSY);
    assign active  = ~s_csel_n & ~busy;
    assign is_cmd  = active & we_rise & s_cmd & ~s_adr;
    assign is_adr  = active & we_rise & s_adr & ~s_cmd;
    assign is_dat  = active & we_rise & ~s_adr & ~s_cmd & (state_q == S_PG_LOAD);
    assign rd_step = active & re_fall & (state_q == S_RD_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= K_READ;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            tmr_q   <= tmr_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        kind_d   = kind_q;
        tmr_d    = tmr_q;
        unique case (state_q)
            S_IDLE, S_RD_DATA: begin
                if (is_cmd) state_d = setup_target(s_dq);
            end
            S_RD_ADDR: begin
                if (is_cmd) begin
                    if (s_dq == OP_RD_GO) begin
                        state_d = S_BUSY;
                        kind_d  = K_READ;
                        tmr_d   = TMR_W'(BUSY_RD - 1);
                    end else begin
                        state_d = setup_target(s_dq);
                    end
                end
            end
            S_PG_LOAD: begin
                if (is_cmd) begin
                    if (s_dq == OP_PG_GO) begin
                        state_d = s_wp_n ? S_BUSY : S_IDLE;
                        kind_d  = K_PROG;
                        tmr_d   = TMR_W'(BUSY_PG - 1);
                    end else begin
                        state_d = setup_target(s_dq);
                    end
                end
            end
            S_ER_ADDR: begin
                if (is_cmd) begin
                    if (s_dq == OP_ER_GO) begin
                        state_d = s_wp_n ? S_BUSY : S_IDLE;
                        kind_d  = K_ERASE;
                        tmr_d   = TMR_W'(BUSY_ER - 1);
                    end else begin
                        state_d = setup_target(s_dq);
                    end
                end
            end
            S_BUSY: begin
                if (tmr_q == '0) state_d = (kind_q == K_READ) ? S_RD_DATA : S_IDLE;
                else             tmr_d   = tmr_q - 1'b1;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        rb_pull_o   = busy;
        standby_o   = s_csel_n & ~busy;
        supply_en_o = s_wp_n;
        dq_oe_o     = ~s_csel_n & ~s_rstb_n & (state_q == S_RD_DATA);
        addr_clr    = is_cmd & (setup_target(s_dq) != S_IDLE);
        arr_prog    = busy & (tmr_q == '0) & (kind_q == K_PROG);
        arr_erase   = busy & (tmr_q == '0) & (kind_q == K_ERASE);
    end

    // command register and read data register
    logic [BUF_DEPTH*8-1:0] stage_mem, arr_mem;
    logic [7:0]             cmd_q, dout_q;
    logic [IDX_W-1:0]       idx;

    assign idx = col_o[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            dout_q <= '0;
        end else begin
            if (is_cmd)  cmd_q  <= s_dq;
            if (rd_step) dout_q <= arr_mem[{idx, 3'b000} +: 8];
        end
    end

    assign cmd_o = cmd_q;
    assign dq_o  = dout_q;

    nand_fe_addr #(
        .ADDR_BYTES (ADDR_BYTES),
        .COL_W      (COL_W)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (addr_clr),
        .addr_wr (is_adr),
        .byte_in (s_dq),
        .col_inc (rd_step | is_dat),
        .addr_q  (addr_o),
        .col_q   (col_o)
    );

    nand_fe_buf #(
        .DEPTH (BUF_DEPTH)
    ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (is_dat),
        .wr_idx   (idx),
        .wr_data  (s_dq),
        .fill_en  (1'b0),
        .copy_en  (1'b0),
        .copy_src ('0),
        .mem_o    (stage_mem)
    );

    nand_fe_buf #(
        .DEPTH (BUF_DEPTH)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (1'b0),
        .wr_idx   ('0),
        .wr_data  (8'h00),
        .fill_en  (arr_erase),
        .copy_en  (arr_prog),
        .copy_src (stage_mem),
        .mem_o    (arr_mem)
    );
endmodule

// File: rtl/nand_fe_checker.sv
module nand_fe_checker
    import nand_fe_pkg::*;
#(
    parameter int COL_W = 16,
    parameter int AW    = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dq_oe_o,
    input logic             rb_pull_o,
    input logic             standby_o,
    input logic [7:0]       cmd_o,
    input logic [AW-1:0]    addr_o,
    input logic [COL_W-1:0] col_o,
    input logic             rd_step,
    input logic             s_wp_n,
    input fe_state_t        state_q,
    input op_kind_t         kind_q
);
    AST_OE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> !rb_pull_o); // R8

    AST_OE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> state_q == S_RD_DATA); // R8

    AST_STANDBY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(standby_o) |-> ($stable(cmd_o) && $stable(addr_o))); // R9

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rb_pull_o) |-> ($stable(cmd_o) && $stable(addr_o))); // R10

    AST_BUSY_NO_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        rb_pull_o |-> !standby_o); // R10

    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_step) |-> col_o == COL_W'($past(col_o) + 1'b1)); // R7

    AST_WP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rb_pull_o) && kind_q != K_READ) |-> $past(s_wp_n)); // R11
endmodule

bind nand_port_frontend nand_fe_checker #(
    .COL_W (COL_W),
    .AW    (8*ADDR_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dq_oe_o   (dq_oe_o),
    .rb_pull_o (rb_pull_o),
    .standby_o (standby_o),
    .cmd_o     (cmd_o),
    .addr_o    (addr_o),
    .col_o     (col_o),
    .rd_step   (rd_step),
    .s_wp_n    (s_wp_n),
    .state_q   (state_q),
    .kind_q    (kind_q)
);

// File: tb/nand_port_frontend_tb.sv
module nand_port_frontend_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        csel_n_i, cmd_sel_i, addr_sel_i, wstb_n_i, rstb_n_i, wprot_n_i;
    logic [7:0]  dq_i;
    logic [7:0]  dq_o;
    logic        dq_oe_o, rb_pull_o, standby_o, supply_en_o;
    logic [7:0]  cmd_o;
    logic [39:0] addr_o;
    logic [15:0] col_o;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    nand_port_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .csel_n_i(csel_n_i), .cmd_sel_i(cmd_sel_i),
        .addr_sel_i(addr_sel_i), .wstb_n_i(wstb_n_i), .rstb_n_i(rstb_n_i),
        .wprot_n_i(wprot_n_i), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
        .rb_pull_o(rb_pull_o), .standby_o(standby_o), .supply_en_o(supply_en_o),
        .cmd_o(cmd_o), .addr_o(addr_o), .col_o(col_o)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic c, input logic a, input logic [7:0] b);
        @(negedge clk);
        cmd_sel_i = c; addr_sel_i = a; dq_i = b; wstb_n_i = 1'b0;
        repeat (3) @(negedge clk);
        wstb_n_i = 1'b1;
        repeat (4) @(negedge clk);
        cmd_sel_i = 1'b0; addr_sel_i = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] v, output logic oe);
        @(negedge clk);
        rstb_n_i = 1'b0;
        repeat (4) @(negedge clk);
        v = dq_o; oe = dq_oe_o;
        rstb_n_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_addr(input logic [7:0] c0);
        wr_byte(1'b0, 1'b1, c0);
        for (int k = 1; k < 5; k++) wr_byte(1'b0, 1'b1, 8'h00);
    endtask

    task automatic wait_ready();
        repeat (40) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       oe;
        logic [7:0] cmd_keep;
        logic [39:0] addr_keep;
        logic [15:0] col_keep;

        rst_n = 1'b0; csel_n_i = 1'b1; cmd_sel_i = 1'b0; addr_sel_i = 1'b0;
        wstb_n_i = 1'b1; rstb_n_i = 1'b1; wprot_n_i = 1'b0; dq_i = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // reset state
        check("R6 reset rb", rb_pull_o, 0);
        check("R8 reset oe", dq_oe_o, 0);
        check("R9 reset standby", standby_o, 1);
        check("R11 reset supply", supply_en_o, 0);
        check("R1 reset cmd", cmd_o, 0);
        check("R2 reset addr", addr_o, 0);

        csel_n_i = 1'b0; wprot_n_i = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 selected", standby_o, 0);
        check("R11 supply on", supply_en_o, 1);

        // R1 command latch
        wr_byte(1'b1, 1'b0, 8'hFF);
        check("R1 cmd", cmd_o, 8'hFF);

        // R2 address order and wrap
        wr_byte(1'b1, 1'b0, 8'h00);
        for (int k = 0; k < 5; k++) wr_byte(1'b0, 1'b1, 8'((k + 1) * 17));
        check("R2 five bytes", addr_o, 40'h5544332211);
        check("R7 col reload", col_o, 16'h2211);
        wr_byte(1'b0, 1'b1, 8'h66);
        check("R2 wrap", addr_o, 40'h5544332266);
        check("R7 col byte0", col_o, 16'h0066);

        // R3 both selects high
        cmd_keep = cmd_o; addr_keep = addr_o; col_keep = col_o;
        wr_byte(1'b1, 1'b1, 8'hA5);
        check("R3 cmd kept", cmd_o, cmd_keep);
        check("R3 addr kept", addr_o, addr_keep);
        check("R3 col kept", col_o, col_keep);
        wr_byte(1'b1, 1'b0, 8'hFF);

        // R4/R5/R6/R12 program a full page
        wr_byte(1'b1, 1'b0, 8'h80);
        send_addr(8'h00);
        for (int i = 0; i < 16; i++) wr_byte(1'b0, 1'b0, pat(i));
        check("R4 col after load", col_o, 16);
        wr_byte(1'b1, 1'b0, 8'h10);
        check("R6 program busy", rb_pull_o, 1);
        repeat (8) @(negedge clk);
        check("R6 program still busy", rb_pull_o, 1);
        wait_ready();
        check("R6 program done", rb_pull_o, 0);

        // R7/R8/R12 read sweep from every start column, with wrap
        for (int s = 0; s < 16; s++) begin
            wr_byte(1'b1, 1'b0, 8'h00);
            send_addr(8'(s));
            wr_byte(1'b1, 1'b0, 8'h30);
            check("R6 read busy", rb_pull_o, 1);
            wait_ready();
            check("R6 read done", rb_pull_o, 0);
            check("R8 oe idle", dq_oe_o, 0);
            for (int k = 0; k < 3; k++) begin
                rd_byte(v, oe);
                check("R7 read data", v, pat((s + k) % 16));
                check("R8 oe during read", oe, 1);
                check("R7 col step", col_o, 16'(s + k + 1));
            end
            check("R8 oe released", dq_oe_o, 0);
        end

        // R8/R9 deselected during read phase
        csel_n_i = 1'b1;
        repeat (4) @(negedge clk);
        col_keep = col_o;
        rd_byte(v, oe);
        check("R8 oe deselected", oe, 0);
        check("R9 col frozen", col_o, col_keep);
        check("R9 standby", standby_o, 1);
        cmd_keep = cmd_o; addr_keep = addr_o;
        wr_byte(1'b1, 1'b0, 8'h60);
        check("R9 cmd ignored", cmd_o, cmd_keep);
        wr_byte(1'b0, 1'b1, 8'h77);
        check("R9 addr ignored", addr_o, addr_keep);
        csel_n_i = 1'b0;
        repeat (4) @(negedge clk);

        // R11 write protect blocks program and erase
        wprot_n_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R11 supply off", supply_en_o, 0);
        wr_byte(1'b1, 1'b0, 8'h80);
        send_addr(8'h00);
        wr_byte(1'b0, 1'b0, 8'h00);
        wr_byte(1'b1, 1'b0, 8'h10);
        check("R11 program blocked", rb_pull_o, 0);
        wr_byte(1'b1, 1'b0, 8'h60);
        send_addr(8'h00);
        wr_byte(1'b1, 1'b0, 8'hD0);
        check("R11 erase blocked", rb_pull_o, 0);
        wr_byte(1'b1, 1'b0, 8'h00);
        send_addr(8'h00);
        wr_byte(1'b1, 1'b0, 8'h30);
        wait_ready();
        for (int k = 0; k < 2; k++) begin
            rd_byte(v, oe);
            check("R11 array unchanged", v, pat(k));
        end
        wprot_n_i = 1'b1;
        repeat (4) @(negedge clk);

        // R10 busy overrides deselect
        wr_byte(1'b1, 1'b0, 8'h80);
        send_addr(8'h00);
        wr_byte(1'b1, 1'b0, 8'h10);
        csel_n_i = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 still busy", rb_pull_o, 1);
        check("R10 no standby", standby_o, 0);
        wait_ready();
        check("R10 completes", rb_pull_o, 0);
        check("R10 standby after", standby_o, 1);
        csel_n_i = 1'b0;
        repeat (4) @(negedge clk);

        // R12 erase fills the page
        wr_byte(1'b1, 1'b0, 8'h60);
        send_addr(8'h00);
        wr_byte(1'b1, 1'b0, 8'hD0);
        check("R6 erase busy", rb_pull_o, 1);
        wait_ready();
        wr_byte(1'b1, 1'b0, 8'h00);
        send_addr(8'h05);
        wr_byte(1'b1, 1'b0, 8'h30);
        wait_ready();
        for (int k = 0; k < 4; k++) begin
            rd_byte(v, oe);
            check("R12 erased byte", v, 8'hFF);
        end

        // R5 reset command returns to idle: no output enable afterwards
        wr_byte(1'b1, 1'b0, 8'hFF);
        rd_byte(v, oe);
        check("R5 reset leaves read phase", oe, 0);

        summary();
        $finish;
    end
endmodule